// File: doc/BRIEF.md
# Fault-Injectable Register-Array Memory

This block is a small synchronous memory built from flops. It has one read/write port and a separate configuration port that lets a test environment plant a single functional fault. The fault sits on one victim cell, given by a word address and a bit index. The disturb kind also uses an aggressor word address. A memory self-test controller can run its march sequences against this model, and the environment knows which fault should be found and where.

Arming is handled by a two-state machine. In `ARM_IDLE` the memory behaves fault-free. A load request without a clear (transition *arm*) moves it to `ARM_LIVE` and captures the kind, victim address, victim bit, aggressor address and polarity. In `ARM_LIVE` a further load (transition *rearm*) replaces the captured configuration and keeps the state. A clear (transition *disarm*) returns to `ARM_IDLE`. A clear in `ARM_IDLE` keeps that state (transition *stay*). Faults change stored data at the same clock edge as the access that triggers them. Reads return data one cycle after the request.

Top module: `fault_inj_sram`

## Requirements
- R1: After reset every word holds zero, the read data output is zero and no fault is armed.
- R2: With no fault armed, a write stores its data at the clock edge. A read presents the stored word on the read data output from the following cycle. The read data output holds its value in every cycle that has no read.
- R3: A load arms the fault given on the configuration inputs from the next cycle on. A memory access in the same cycle as the load still sees the previous configuration. A clear disarms, and a clear wins over a simultaneous load. Kind codes: 0 stuck, 1 read-flip, 2 late-flip, 3 write-flip, 4 read-lie, 5 transition-block, 6 disturb, 7 none.
- R4: Stuck (code 0): a read of the victim word returns the polarity bit at the victim bit position, and any write there stores the polarity bit.
- R5: Read-flip (code 1): a read of the victim word inverts the victim bit in storage and returns the inverted value.
- R6: Late-flip (code 2): a read of the victim word returns the correct value and inverts the stored victim bit.
- R7: Write-flip (code 3): a write whose victim-bit value equals the stored bit stores the inverse of that bit. A write that changes the bit behaves normally.
- R8: Read-lie (code 4): a read of the victim word returns the victim bit inverted, and the stored cell is left unchanged.
- R9: Transition-block (code 5): a write that would change the victim bit in either direction leaves that bit at its old value.
- R10: Disturb (code 6): any read or write of the aggressor word inverts the stored victim bit.
- R11: Other addresses, and other bits of the victim word, behave fault-free, and code 7 has no effect anywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_en | input | 1 | Access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | AW | Word address |
| mem_wdata | input | WIDTH | Write data |
| mem_rdata | output | WIDTH | Registered read data |
| cfg_load | input | 1 | Capture the fault configuration and arm it |
| cfg_clear | input | 1 | Disarm; takes priority over load |
| cfg_kind | input | 3 | Fault kind code |
| cfg_victim_addr | input | AW | Victim word address |
| cfg_victim_bit | input | BW | Victim bit index |
| cfg_aggr_addr | input | AW | Aggressor word address (disturb kind) |
| cfg_polarity | input | 1 | Stuck value |

## Verification
Two things can happen in the same clock cycle: a configuration change (load, or load with clear) and a memory access to the victim word. The bench provokes this in two ways. It issues a load of a read-flip fault together with a read of the victim word, and it issues a load together with a clear, followed by reads of the victim. The coinciding read must return clean data, and only the next read may show the fault. A load with a clear must leave every later read clean.

// File: rtl/fim_pkg.sv
package fim_pkg;

    typedef enum logic [2:0] {
        FT_STUCK          = 3'd0,
        FT_READ_FLIP      = 3'd1,
        FT_READ_LATE_FLIP = 3'd2,
        FT_WRITE_FLIP     = 3'd3,
        FT_READ_LIE       = 3'd4,
        FT_TRANS_BLOCK    = 3'd5,
        FT_DISTURB        = 3'd6,
        FT_NONE           = 3'd7
    } fault_kind_e;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_LIVE = 1'b1
    } arm_state_e;

endpackage

// File: rtl/fim_arm_ctrl.sv
module fim_arm_ctrl
    import fim_pkg::*;
#(
    parameter int AW = 4,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clear,
    input  logic [2:0]    kind_in,
    input  logic [AW-1:0] vaddr_in,
    input  logic [BW-1:0] vbit_in,
    input  logic [AW-1:0] aaddr_in,
    input  logic          pol_in,
    output logic          armed,
    output fault_kind_e   kind,
    output logic [AW-1:0] vaddr,
    output logic [BW-1:0] vbit,
    output logic [AW-1:0] aaddr,
    output logic          pol
);

    arm_state_e state_q, state_d;
    logic       capture;

    assign capture = load && !clear;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_IDLE: if (capture) state_d = ARM_LIVE;   // arm
            ARM_LIVE: if (clear)   state_d = ARM_IDLE;   // disarm (rearm keeps LIVE)
            default:               state_d = ARM_IDLE;
        endcase
    end

    // state register and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
            kind    <= FT_NONE;
            vaddr   <= '0;
            vbit    <= '0;
            aaddr   <= '0;
            pol     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                kind  <= fault_kind_e'(kind_in);
                vaddr <= vaddr_in;
                vbit  <= vbit_in;
                aaddr <= aaddr_in;
                pol   <= pol_in;
            end
        end
    end

    // outputs
    always_comb begin
        armed = (state_q == ARM_LIVE);
    end

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !armed);

    a_r3_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (armed && kind == fault_kind_e'($past(kind_in))));

endmodule

// File: rtl/fim_cell_effect.sv
module fim_cell_effect
    import fim_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int BW    = 3
) (
    input  logic             hit,
    input  logic             is_write,
    input  fault_kind_e      kind,
    input  logic [BW-1:0]    vbit,
    input  logic             pol,
    input  logic [WIDTH-1:0] old_word,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] new_word,
    output logic [WIDTH-1:0] read_word
);

    logic old_b;
    logic wr_b;

    always_comb begin
        old_b     = old_word[vbit];
        wr_b      = wdata[vbit];
        new_word  = is_write ? wdata : old_word;
        read_word = old_word;
        if (hit) begin
            unique case (kind)
                FT_STUCK: begin
                    new_word[vbit]  = pol;
                    read_word[vbit] = pol;
                end
                FT_READ_FLIP: begin
                    if (!is_write) begin
                        new_word[vbit]  = ~old_b;
                        read_word[vbit] = ~old_b;
                    end
                end
                FT_READ_LATE_FLIP: begin
                    if (!is_write) new_word[vbit] = ~old_b;
                end
                FT_WRITE_FLIP: begin
                    if (is_write && (wr_b == old_b)) new_word[vbit] = ~old_b;
                end
                FT_READ_LIE: begin
                    if (!is_write) read_word[vbit] = ~old_b;
                end
                FT_TRANS_BLOCK: begin
                    if (is_write && (wr_b != old_b)) new_word[vbit] = old_b;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/fault_inj_sram.sv
module fault_inj_sram
    import fim_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_en,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_addr,
    input  logic [WIDTH-1:0] mem_wdata,
    output logic [WIDTH-1:0] mem_rdata,
    input  logic             cfg_load,
    input  logic             cfg_clear,
    input  logic [2:0]       cfg_kind,
    input  logic [AW-1:0]    cfg_victim_addr,
    input  logic [BW-1:0]    cfg_victim_bit,
    input  logic [AW-1:0]    cfg_aggr_addr,
    input  logic             cfg_polarity
);

    logic             armed;
    fault_kind_e      f_kind;
    logic [AW-1:0]    f_vaddr;
    logic [BW-1:0]    f_vbit;
    logic [AW-1:0]    f_aaddr;
    logic             f_pol;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] cur_word;
    logic [WIDTH-1:0] new_word;
    logic [WIDTH-1:0] read_word;
    logic             victim_hit;
    logic             disturb_fire;
    logic             rd_req;

    fim_arm_ctrl #(.AW(AW), .BW(BW)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .clear    (cfg_clear),
        .kind_in  (cfg_kind),
        .vaddr_in (cfg_victim_addr),
        .vbit_in  (cfg_victim_bit),
        .aaddr_in (cfg_aggr_addr),
        .pol_in   (cfg_polarity),
        .armed    (armed),
        .kind     (f_kind),
        .vaddr    (f_vaddr),
        .vbit     (f_vbit),
        .aaddr    (f_aaddr),
        .pol      (f_pol)
    );

    assign cur_word     = mem_q[mem_addr];
    assign rd_req       = mem_en && !mem_we;
    assign victim_hit   = armed && (mem_addr == f_vaddr);
    assign disturb_fire = mem_en && armed && (f_kind == FT_DISTURB) && (mem_addr == f_aaddr);

    fim_cell_effect #(.WIDTH(WIDTH), .BW(BW)) i_effect (
        .hit       (victim_hit),
        .is_write  (mem_we),
        .kind      (f_kind),
        .vbit      (f_vbit),
        .pol       (f_pol),
        .old_word  (cur_word),
        .wdata     (mem_wdata),
        .new_word  (new_word),
        .read_word (read_word)
    );

    // next contents of every word
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (mem_en && (mem_addr == AW'(i))) mem_d[i] = new_word;
            if (disturb_fire && (f_vaddr == AW'(i))) mem_d[i][f_vbit] = ~mem_d[i][f_vbit];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            mem_rdata <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            if (rd_req) mem_rdata <= read_word;
        end
    end

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(mem_rdata));

    a_r4_stuck_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && victim_hit && f_kind == FT_STUCK)
        |=> mem_rdata[$past(f_vbit)] == $past(f_pol));

    a_r5_flip_returns_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && victim_hit && f_kind == FT_READ_FLIP)
        |=> mem_rdata[$past(f_vbit)] != $past(cur_word[f_vbit]));

    a_r8_lie_keeps_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && victim_hit && f_kind == FT_READ_LIE)
        |=> mem_q[$past(mem_addr)] == $past(cur_word));

endmodule

// File: tb/test_fault_inj_sram.sv
module test_fault_inj_sram;

    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;
    localparam logic [1:0] OP_A = 2'd2;
    localparam logic [1:0] OP_C = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] addr;
        logic [7:0] data;
        logic [2:0] kind;
        logic [2:0] vbit;
        logic [3:0] aaddr;
        logic       pol;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 52;
    localparam vec_t TBL [NV] = '{
        '{OP_W, 4'd3,  8'h5A, 3'd0, 3'd0, 4'd0,  1'b0, 4'd2 },
        '{OP_R, 4'd3,  8'h5A, 3'd0, 3'd0, 4'd0,  1'b0, 4'd2 },  // R2
        '{OP_A, 4'd3,  8'h00, 3'd0, 3'd0, 4'd0,  1'b1, 4'd4 },
        '{OP_R, 4'd3,  8'h5B, 3'd0, 3'd0, 4'd0,  1'b0, 4'd4 },  // R4
        '{OP_W, 4'd3,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd4 },
        '{OP_R, 4'd3,  8'h01, 3'd0, 3'd0, 4'd0,  1'b0, 4'd4 },
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_R, 4'd3,  8'h01, 3'd0, 3'd0, 4'd0,  1'b0, 4'd4 },
        '{OP_A, 4'd4,  8'h00, 3'd1, 3'd7, 4'd0,  1'b0, 4'd5 },
        '{OP_R, 4'd4,  8'h80, 3'd0, 3'd0, 4'd0,  1'b0, 4'd5 },  // R5
        '{OP_R, 4'd4,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd5 },
        '{OP_R, 4'd11, 8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd11},  // R11
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_R, 4'd4,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd5 },
        '{OP_A, 4'd5,  8'h00, 3'd2, 3'd1, 4'd0,  1'b0, 4'd6 },
        '{OP_R, 4'd5,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd6 },  // R6
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_R, 4'd5,  8'h02, 3'd0, 3'd0, 4'd0,  1'b0, 4'd6 },
        '{OP_A, 4'd6,  8'h00, 3'd3, 3'd2, 4'd0,  1'b0, 4'd7 },
        '{OP_W, 4'd6,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd7 },
        '{OP_R, 4'd6,  8'h04, 3'd0, 3'd0, 4'd0,  1'b0, 4'd7 },  // R7
        '{OP_W, 4'd6,  8'h04, 3'd0, 3'd0, 4'd0,  1'b0, 4'd7 },
        '{OP_R, 4'd6,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd7 },
        '{OP_W, 4'd6,  8'h04, 3'd0, 3'd0, 4'd0,  1'b0, 4'd7 },
        '{OP_R, 4'd6,  8'h04, 3'd0, 3'd0, 4'd0,  1'b0, 4'd7 },
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_A, 4'd7,  8'h00, 3'd4, 3'd3, 4'd0,  1'b0, 4'd8 },
        '{OP_W, 4'd7,  8'h08, 3'd0, 3'd0, 4'd0,  1'b0, 4'd8 },
        '{OP_R, 4'd7,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd8 },  // R8
        '{OP_R, 4'd7,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd8 },
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_R, 4'd7,  8'h08, 3'd0, 3'd0, 4'd0,  1'b0, 4'd8 },
        '{OP_A, 4'd8,  8'h00, 3'd5, 3'd4, 4'd0,  1'b0, 4'd9 },
        '{OP_W, 4'd8,  8'h10, 3'd0, 3'd0, 4'd0,  1'b0, 4'd9 },
        '{OP_R, 4'd8,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd9 },  // R9
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_W, 4'd8,  8'h10, 3'd0, 3'd0, 4'd0,  1'b0, 4'd9 },
        '{OP_A, 4'd8,  8'h00, 3'd5, 3'd4, 4'd0,  1'b0, 4'd9 },
        '{OP_W, 4'd8,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd9 },
        '{OP_R, 4'd8,  8'h10, 3'd0, 3'd0, 4'd0,  1'b0, 4'd9 },
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_A, 4'd9,  8'h00, 3'd6, 3'd5, 4'd10, 1'b0, 4'd10},
        '{OP_R, 4'd10, 8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd10},  // R10
        '{OP_W, 4'd10, 8'h11, 3'd0, 3'd0, 4'd0,  1'b0, 4'd10},
        '{OP_R, 4'd10, 8'h11, 3'd0, 3'd0, 4'd0,  1'b0, 4'd10},
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 },
        '{OP_R, 4'd9,  8'h20, 3'd0, 3'd0, 4'd0,  1'b0, 4'd10},
        '{OP_A, 4'd3,  8'h00, 3'd7, 3'd0, 4'd0,  1'b0, 4'd11},
        '{OP_R, 4'd3,  8'h01, 3'd0, 3'd0, 4'd0,  1'b0, 4'd11},
        '{OP_W, 4'd3,  8'hFF, 3'd0, 3'd0, 4'd0,  1'b0, 4'd11},
        '{OP_R, 4'd3,  8'hFF, 3'd0, 3'd0, 4'd0,  1'b0, 4'd11},
        '{OP_C, 4'd0,  8'h00, 3'd0, 3'd0, 4'd0,  1'b0, 4'd3 }
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mem_en, mem_we;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic       cfg_load, cfg_clear;
    logic [2:0] cfg_kind;
    logic [3:0] cfg_victim_addr;
    logic [2:0] cfg_victim_bit;
    logic [3:0] cfg_aggr_addr;
    logic       cfg_polarity;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_inj_sram #(.DEPTH(16), .WIDTH(8)) i_fault_inj_sram (
        .clk             (clk),
        .rst_n           (rst_n),
        .mem_en          (mem_en),
        .mem_we          (mem_we),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .mem_rdata       (mem_rdata),
        .cfg_load        (cfg_load),
        .cfg_clear       (cfg_clear),
        .cfg_kind        (cfg_kind),
        .cfg_victim_addr (cfg_victim_addr),
        .cfg_victim_bit  (cfg_victim_bit),
        .cfg_aggr_addr   (cfg_aggr_addr),
        .cfg_polarity    (cfg_polarity)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mem_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
        cfg_load = 1'b0; cfg_clear = 1'b0; cfg_kind = '0;
        cfg_victim_addr = '0; cfg_victim_bit = '0; cfg_aggr_addr = '0; cfg_polarity = 1'b0;
    endtask

    // one cycle: drive at a falling edge, settle through the rising edge, return at the next falling edge
    task automatic do_read(input logic [3:0] a);
        mem_en = 1'b1; mem_we = 1'b0; mem_addr = a;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic apply(input vec_t v);
        unique case (v.op)
            OP_W: begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = v.addr; mem_wdata = v.data; end
            OP_R: begin mem_en = 1'b1; mem_we = 1'b0; mem_addr = v.addr; end
            OP_A: begin
                cfg_load = 1'b1; cfg_kind = v.kind; cfg_victim_addr = v.addr;
                cfg_victim_bit = v.vbit; cfg_aggr_addr = v.aaddr; cfg_polarity = v.pol;
            end
            default: cfg_clear = 1'b1;
        endcase
        @(negedge clk);
        idle_inputs();
        if (v.op == OP_R) check($sformatf("R%0d vector", v.req), mem_rdata, v.data);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [7:0] held;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata after reset", mem_rdata, 8'h00);
        do_read(4'd0);
        check("R1 word 0 after reset", mem_rdata, 8'h00);
        do_read(4'd15);
        check("R1 word 15 after reset", mem_rdata, 8'h00);

        for (int k = 0; k < NV; k++) apply(TBL[k]);

        // R2: output holds across idle cycles
        do_read(4'd3);
        held = mem_rdata;
        @(negedge clk);
        @(negedge clk);
        check("R2 rdata held while idle", mem_rdata, held);

        // R3: load with clear in the same cycle leaves memory clean
        cfg_load = 1'b1; cfg_clear = 1'b1; cfg_kind = 3'd1;
        cfg_victim_addr = 4'd12; cfg_victim_bit = 3'd0;
        @(negedge clk);
        idle_inputs();
        do_read(4'd12);
        check("R3 clear beats load, first read", mem_rdata, 8'h00);
        do_read(4'd12);
        check("R3 clear beats load, second read", mem_rdata, 8'h00);

        // R3: load coinciding with a victim read; the read sees the old configuration
        cfg_load = 1'b1; cfg_kind = 3'd1; cfg_victim_addr = 4'd13; cfg_victim_bit = 3'd0;
        mem_en = 1'b1; mem_we = 1'b0; mem_addr = 4'd13;
        @(negedge clk);
        idle_inputs();
        check("R3 read in load cycle is clean", mem_rdata, 8'h00);
        do_read(4'd13);
        check("R3 fault active after load", mem_rdata, 8'h01);
        cfg_clear = 1'b1;
        @(negedge clk);
        idle_inputs();
        do_read(4'd13);
        check("R3 cleared, flipped cell persists", mem_rdata, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule